// File: doc/BRIEF.md
# Crosshair Cursor Overlay Generator

This block draws a full-screen crosshair cursor at pixel rate. A host writes one control byte through an indexed register port. The raster timing supplies horizontal and vertical pixel counters and an active-video flag. On every pixel clock the block reports whether the current pixel belongs to the crosshair and which of two cursor colours a downstream palette should use for it.

The vertical bar and the horizontal bar each have a selectable thickness of 1, 3, 5 or 7 pixels. Both bars are centred on the programmed X and Y cursor position, and they are clipped at the screen edges without wrapping. The same control byte also holds two sprite-cursor settings. The block does not act on them and only drives them out to the sprite logic, which lives elsewhere.

Top module: `xhair_overlay`

## Requirements
- R1: After a synchronous active-low reset, every control bit is 0. `hit`, `color_sel`, `sprite_en` and `sprite_fmt` are then all 0.
- R2: A write changes the control byte only when `reg_wr` is high and `reg_idx` equals 0x06. Writes to any other index have no effect.
- R3: Control bit 6 drives `sprite_en` and control bit 4 drives `sprite_fmt`, where 0 selects the first sprite data format and 1 the second. Both outputs change on the clock edge that samples the write.
- R4: Control bit 2 enables the crosshair. While it is 0, `hit` stays 0.
- R5: A pixel is a hit when `active` is 1, the crosshair is enabled, and either `h_cnt` lies in the vertical bar or `v_cnt` lies in the horizontal bar.
- R6: Control bits 1:0 set the thickness: code n gives 2n+1 pixels. For cursor position p, the band covers p-n to p+n.
- R7: The band is clipped at counter 0 and at the counter maximum. No counter value wraps into the band.
- R8: `color_sel` equals control bit 3 (0 = colour 0, 1 = colour 1) on hit pixels and is 0 otherwise.
- R9: `hit` and `color_sel` are registered and reflect the inputs one clock earlier. A control write affects them from the clock after the write is sampled.
- R10: Control bits 7 and 5 have no effect on any output.
- R11: When `active` is 0, `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_idx | input | 8 | Host register index |
| reg_data | input | 8 | Host write data |
| cur_x | input | 12 | Cursor X position |
| cur_y | input | 12 | Cursor Y position |
| h_cnt | input | 12 | Horizontal pixel counter |
| v_cnt | input | 12 | Vertical pixel counter |
| active | input | 1 | Active-video flag |
| hit | output | 1 | Pixel belongs to the crosshair (registered) |
| color_sel | output | 1 | Cursor colour for a hit pixel (registered) |
| sprite_en | output | 1 | Sprite cursor enable from control bit 6 |
| sprite_fmt | output | 1 | Sprite data format from control bit 4 |

## Verification
The embedded assertions check the following on every cycle: a hit only follows a cycle with active video and the crosshair enabled, a colour select of 1 never appears without a hit, the control byte never changes without a matching write, and the pixel at the cursor position always falls inside its band while a pixel more than three away never does. Other properties depend on particular values, and only the bench's scenarios show them. These are the exact band edges for each thickness, the clipping at both screen ends, the one-clock lag, the ignored reserved bits and the ignored wrong-index writes.

// File: rtl/xhair_pkg.sv
// Shared types and field positions for the crosshair overlay.
// Assumes an 8-bit host data bus whose bit k maps to control bit k.
package xhair_pkg;

    // Decoded control byte. Bits 7 and 5 are not stored.
    typedef struct packed {
        logic       sprite_en;
        logic       sprite_fmt;
        logic       xh_color;
        logic       xh_en;
        logic [1:0] thick;
    } xh_ctrl_t;

    localparam int unsigned BIT_SPRITE_EN  = 6;
    localparam int unsigned BIT_SPRITE_FMT = 4;
    localparam int unsigned BIT_XH_COLOR   = 3;
    localparam int unsigned BIT_XH_EN      = 2;
    localparam int unsigned BIT_THICK_LO   = 0;

    localparam int unsigned NUM_AXES = 2;

endpackage

// File: rtl/xhair_ctrl_reg.sv
// Host-writable control register for the crosshair overlay.
// What it does: on a write strobe whose index matches CTRL_IDX, it captures
// the meaningful bits of the data byte. Reserved bits are dropped.
// Assumes: the write is sampled on the pixel clock and the reset is
// synchronous and active low.
module xhair_ctrl_reg
    import xhair_pkg::*;
#(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned DATA_W   = 8,
    parameter logic [IDX_W-1:0] CTRL_IDX = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    output xh_ctrl_t          ctrl
);

    logic     sel;
    xh_ctrl_t nxt;

    // Decode the index and the field positions of the incoming byte.
    always_comb begin
        sel            = wr && (idx == CTRL_IDX);
        nxt.sprite_en  = data[BIT_SPRITE_EN];
        nxt.sprite_fmt = data[BIT_SPRITE_FMT];
        nxt.xh_color   = data[BIT_XH_COLOR];
        nxt.xh_en      = data[BIT_XH_EN];
        nxt.thick      = data[BIT_THICK_LO +: 2];
    end

    // Hold the control state and load it on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)   ctrl <= '0;
        else if (sel) ctrl <= nxt;
    end

    // R2
    ctrl_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sel)) |-> $stable(ctrl));

endmodule

// File: rtl/xhair_band.sv
// Band comparator for one axis of the crosshair.
// What it does: it reports whether a pixel counter lies within pos +/- code,
// where code is the 2-bit thickness code, so the band width is 2*code+1.
// Assumes: the comparison uses one extra bit, so the band clips at 0 and at
// the counter maximum and no value wraps into it.
module xhair_band #(
    parameter int unsigned CNT_W = 12
) (
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       code,
    output logic             in_band
);

    localparam int unsigned EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] half_e;
    logic [EXT_W-1:0] pos_e;
    logic [EXT_W-1:0] cnt_e;

    // Widen the operands so that neither sum can overflow.
    always_comb begin
        half_e  = {{(EXT_W-2){1'b0}}, code};
        pos_e   = {1'b0, pos};
        cnt_e   = {1'b0, cnt};
        in_band = ((cnt_e + half_e) >= pos_e) && (cnt_e <= (pos_e + half_e));
    end

    // R6: the cursor position always lies in its own band, and a pixel
    // more than three beyond it never does.
    always_comb begin
        if (cnt == pos) begin
            center_in_band_chk: assert (in_band);
        end
        if (cnt_e > pos_e + 3 || cnt_e + 3 < pos_e) begin
            far_out_band_chk: assert (!in_band);
        end
    end

endmodule

// File: rtl/xhair_overlay.sv
// Crosshair cursor overlay generator, top level.
// What it does: it holds the control byte, compares both pixel counters
// against the cursor bands and registers the hit flag and colour select.
// It passes the sprite control bits straight out.
// Assumes: the counters and the active flag are aligned to the pixel clock.
// The outputs lag them by one clock.
module xhair_overlay
    import xhair_pkg::*;
#(
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [IDX_W-1:0] CTRL_IDX = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_data,
    input  logic [CNT_W-1:0]  cur_x,
    input  logic [CNT_W-1:0]  cur_y,
    input  logic [CNT_W-1:0]  h_cnt,
    input  logic [CNT_W-1:0]  v_cnt,
    input  logic              active,
    output logic              hit,
    output logic              color_sel,
    output logic              sprite_en,
    output logic              sprite_fmt
);

    xh_ctrl_t         ctrl;
    logic [CNT_W-1:0] axis_pos [NUM_AXES];
    logic [CNT_W-1:0] axis_cnt [NUM_AXES];
    logic [NUM_AXES-1:0] axis_hit;
    logic             hit_d;

    xhair_ctrl_reg #(
        .IDX_W    (IDX_W),
        .DATA_W   (DATA_W),
        .CTRL_IDX (CTRL_IDX)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .idx   (reg_idx),
        .data  (reg_data),
        .ctrl  (ctrl)
    );

    // Route axis 0 (vertical bar, X) and axis 1 (horizontal bar, Y).
    always_comb begin
        axis_pos[0] = cur_x;
        axis_cnt[0] = h_cnt;
        axis_pos[1] = cur_y;
        axis_cnt[1] = v_cnt;
    end

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        xhair_band #(.CNT_W(CNT_W)) u_band (
            .pos     (axis_pos[a]),
            .cnt     (axis_cnt[a]),
            .code    (ctrl.thick),
            .in_band (axis_hit[a])
        );
    end

    // Combine the active flag, the enable and the two bands.
    always_comb hit_d = active && ctrl.xh_en && (|axis_hit);

    // Register the hit flag and the colour select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit       <= 1'b0;
            color_sel <= 1'b0;
        end else begin
            hit       <= hit_d;
            color_sel <= hit_d && ctrl.xh_color;
        end
    end

    // Drive the sprite control bits out unchanged.
    always_comb begin
        sprite_en  = ctrl.sprite_en;
        sprite_fmt = ctrl.sprite_fmt;
    end

    // R4
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(ctrl.xh_en));

    // R11
    hit_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(active));

    // R8
    color_only_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        color_sel |-> hit);

    // R5
    hit_needs_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(|axis_hit));

endmodule

// File: tb/xhair_overlay_bench.sv
// Self-checking bench for the crosshair overlay: a vector table walked by
// one loop, then directed tests for reset, register access, timing and
// pass-through bits.
module xhair_overlay_bench;

    localparam int unsigned CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             reg_wr;
    logic [7:0]       reg_idx;
    logic [7:0]       reg_data;
    logic [CNT_W-1:0] cur_x, cur_y, h_cnt, v_cnt;
    logic             active;
    logic             hit, color_sel, sprite_en, sprite_fmt;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    xhair_overlay u_xhair_overlay (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_idx    (reg_idx),
        .reg_data   (reg_data),
        .cur_x      (cur_x),
        .cur_y      (cur_y),
        .h_cnt      (h_cnt),
        .v_cnt      (v_cnt),
        .active     (active),
        .hit        (hit),
        .color_sel  (color_sel),
        .sprite_en  (sprite_en),
        .sprite_fmt (sprite_fmt)
    );

    typedef struct packed {
        logic [7:0]       ctrl;
        logic [CNT_W-1:0] cx;
        logic [CNT_W-1:0] cy;
        logic [CNT_W-1:0] h;
        logic [CNT_W-1:0] v;
        logic             act;
        logic             e_hit;
        logic             e_col;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{8'h04, 12'd100, 12'd50, 12'd100, 12'd10, 1'b1, 1'b1, 1'b0},   // R5 vertical bar, thickness 1
        '{8'h04, 12'd100, 12'd50, 12'd101, 12'd10, 1'b1, 1'b0, 1'b0},   // R6 just outside width 1
        '{8'h04, 12'd100, 12'd50, 12'd200, 12'd50, 1'b1, 1'b1, 1'b0},   // R5 horizontal bar
        '{8'h0C, 12'd100, 12'd50, 12'd100, 12'd50, 1'b1, 1'b1, 1'b1},   // R8 colour 1
        '{8'h00, 12'd100, 12'd50, 12'd100, 12'd50, 1'b1, 1'b0, 1'b0},   // R4 disabled
        '{8'h08, 12'd100, 12'd50, 12'd100, 12'd50, 1'b1, 1'b0, 1'b0},   // R4/R8 colour but disabled
        '{8'h0D, 12'd100, 12'd50, 12'd101, 12'd0,  1'b1, 1'b1, 1'b1},   // R6 width 3 edge
        '{8'h0D, 12'd100, 12'd50, 12'd102, 12'd0,  1'b1, 1'b0, 1'b0},   // R6 width 3 outside
        '{8'h06, 12'd100, 12'd50, 12'd98,  12'd0,  1'b1, 1'b1, 1'b0},   // R6 width 5 low edge
        '{8'h06, 12'd100, 12'd50, 12'd97,  12'd0,  1'b1, 1'b0, 1'b0},   // R6 width 5 outside
        '{8'h07, 12'd100, 12'd50, 12'd103, 12'd0,  1'b1, 1'b1, 1'b0},   // R6 width 7 high edge
        '{8'h07, 12'd100, 12'd50, 12'd104, 12'd0,  1'b1, 1'b0, 1'b0},   // R6 width 7 outside
        '{8'h07, 12'd100, 12'd50, 12'd0,   12'd53, 1'b1, 1'b1, 1'b0},   // R6 horizontal width 7 edge
        '{8'h07, 12'd100, 12'd50, 12'd0,   12'd54, 1'b1, 1'b0, 1'b0},   // R6 horizontal outside
        '{8'h07, 12'd0,   12'd2000, 12'd0,  12'd1000, 1'b1, 1'b1, 1'b0}, // R7 clip low, at 0
        '{8'h07, 12'd0,   12'd2000, 12'd3,  12'd1000, 1'b1, 1'b1, 1'b0}, // R7 clip low, edge
        '{8'h07, 12'd0,   12'd2000, 12'd4,  12'd1000, 1'b1, 1'b0, 1'b0}, // R7 clip low, outside
        '{8'h07, 12'd0,   12'd2000, 12'd4095, 12'd1000, 1'b1, 1'b0, 1'b0}, // R7 no wrap from max
        '{8'h07, 12'd4095, 12'd2000, 12'd4092, 12'd1000, 1'b1, 1'b1, 1'b0}, // R7 clip high edge
        '{8'h07, 12'd4095, 12'd2000, 12'd0,   12'd1000, 1'b1, 1'b0, 1'b0}, // R7 no wrap to 0
        '{8'h04, 12'd100, 12'd50, 12'd100, 12'd50, 1'b0, 1'b0, 1'b0},   // R11 blanking
        '{8'h84, 12'd100, 12'd50, 12'd100, 12'd10, 1'b1, 1'b1, 1'b0},   // R10 bit 7 ignored
        '{8'hA4, 12'd100, 12'd50, 12'd101, 12'd10, 1'b1, 1'b0, 1'b0},   // R10 bits 7,5 ignored
        '{8'h2C, 12'd100, 12'd50, 12'd100, 12'd10, 1'b1, 1'b1, 1'b1}    // R10 bit 5 ignored
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Write one byte; the register loads on the next rising edge.
    task automatic host_write(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_wr   = 1'b1;
        reg_idx  = idx;
        reg_data = d;
        @(negedge clk);
        reg_wr   = 1'b0;
    endtask

    task automatic set_pix(input logic [CNT_W-1:0] h, input logic [CNT_W-1:0] v,
                           input logic a);
        h_cnt  = h;
        v_cnt  = v;
        active = a;
    endtask

    initial begin
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_idx = '0; reg_data = '0;
        cur_x = '0; cur_y = '0; active = 1'b0; h_cnt = '0; v_cnt = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 hit", hit, 1'b0);
        check("R1 color_sel", color_sel, 1'b0);
        check("R1 sprite_en", sprite_en, 1'b0);
        check("R1 sprite_fmt", sprite_fmt, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        set_pix(12'd0, 12'd0, 1'b1);
        @(negedge clk);
        check("R1 disabled after reset", hit, 1'b0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            host_write(8'h06, VECS[i].ctrl);
            cur_x = VECS[i].cx;
            cur_y = VECS[i].cy;
            set_pix(VECS[i].h, VECS[i].v, VECS[i].act);
            @(negedge clk);
            check($sformatf("R5/R6 vec %0d hit", i), hit, VECS[i].e_hit);
            check($sformatf("R8 vec %0d color", i), color_sel, VECS[i].e_col);
        end

        // R10 / R3: bits 7 and 5 do not reach the sprite outputs
        host_write(8'h06, 8'hA0);
        check("R10 sprite_en", sprite_en, 1'b0);
        check("R10 sprite_fmt", sprite_fmt, 1'b0);

        // R3: sprite bits pass through on the write edge
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 8'h06; reg_data = 8'h50;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        check("R3 sprite_en", sprite_en, 1'b1);
        check("R3 sprite_fmt", sprite_fmt, 1'b1);
        host_write(8'h06, 8'h10);
        check("R3 sprite_en off", sprite_en, 1'b0);
        check("R3 sprite_fmt only", sprite_fmt, 1'b1);

        // R2: writes to another index are ignored
        host_write(8'h06, 8'h4C);
        host_write(8'h05, 8'h00);
        host_write(8'h07, 8'h00);
        check("R2 sprite_en held", sprite_en, 1'b1);
        cur_x = 12'd10; cur_y = 12'd10;
        set_pix(12'd10, 12'd300, 1'b1);
        @(negedge clk);
        check("R2 crosshair still on", hit, 1'b1);
        check("R2 colour still 1", color_sel, 1'b1);

        // R9: one-clock lag, observed just before the next edge
        set_pix(12'd300, 12'd300, 1'b1);
        @(posedge clk); #1;
        check("R9 hit after edge", hit, 1'b0);
        set_pix(12'd10, 12'd300, 1'b1);
        #2;
        check("R9 hit held before edge", hit, 1'b0);
        @(posedge clk); #1;
        check("R9 hit one clock later", hit, 1'b1);

        // R9: a write affects hit from the clock after it is sampled
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 8'h06; reg_data = 8'h00;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        check("R9 hit old ctrl at write edge", hit, 1'b1);
        @(posedge clk); #1;
        check("R9 hit new ctrl next edge", hit, 1'b0);

        // R1: reset mid-run clears everything
        host_write(8'h06, 8'h5C);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 hit cleared", hit, 1'b0);
        check("R1 sprite cleared", sprite_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 crosshair off after reset", hit, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule